// File: doc/BRIEF.md
# Square-Array Chess Move Generator

This block finds chess moves for one side. It does not loop over the pieces. Instead it holds a grid of 64 identical square cells. Each cell knows what occupies its square, and it is wired to its neighbours along the eight compass directions and the eight knight jumps. Signals start at some cells and move across the grid. A cell receives signals and, based on its occupant, decides whether to pass them on. Sliding signals continue through empty squares and stop at the first occupied square. Single-step, knight and pawn signals travel exactly one hop. All cells settle in the same evaluation, and the resulting 64-bit flag vector is registered once.

The grid runs in one of two modes. In destination mode, every piece of the side to move starts its own movement pattern. Each cell then raises its flag if a pseudo-legal move of that side can land on it. In origin mode, a single selected target square starts a combined pattern that covers every piece type. A cell raises its flag when it holds a piece of the side to move that can answer the signal arriving from that direction, such as a rook reached along a file. The flags are then exactly the origins of moves onto the target. A search controller uses destination mode to choose a target square, then uses origin mode to find the pieces that can move there. Check legality, castling, en passant, double pawn steps and promotion are not handled.

Top module: `sqgrid_movegen`

## Requirements
- R1: Board and flag encoding:
  - Square s is rank*8+file, so a1=0, h1=7, a2=8 and h8=63.
  - `board_i[4s+3:4s]` holds the occupant of square s. Bits 2:0 give the type: 0 empty, 1 pawn, 2 knight, 3 bishop, 4 rook, 5 queen, 6 king. Bit 3 is the colour, with 1 meaning black.
  - `side_i` selects the side to move, with 0 meaning white. `mode_i` selects the mode: 0 is destination mode and 1 is origin mode.
  - `flags_o` bit s reports square s one clock after the inputs are presented. While `rst_n` is low, `flags_o` reads zero. An empty board gives zero flags.
- R2: A bishop, rook or queen reaches every square along its lines (diagonal, orthogonal, or both) until the first occupied square. That square counts only if it holds an enemy piece. Rays never wrap from one edge of the board to the opposite edge.
- R3: A knight reaches its jump squares and a king reaches its adjacent squares, provided each such square is on the board and not occupied by an own piece.
- R4: A pawn reaches the single square straight ahead only when that square is empty. It reaches the two squares diagonally ahead only when they hold an enemy piece. There are no double steps.
- R5: In destination mode, a square holding a piece of the side to move is never flagged.
- R6: In origin mode, with a target square that is empty or holds an enemy piece, bit s is set exactly when the own piece on s has a move (as defined by R2 to R4) onto the target.
- R7: In origin mode, if the target square holds a piece of the side to move, every flag is zero.
- R8: In origin mode, flags appear only on squares holding pieces of the side to move. At most one cell, the target, starts signals.
- R9: White pawns move toward higher ranks and black pawns toward lower ranks. `side_i` selects which colour moves.
- R10: For any board and side, the destination-mode flag of square t is set exactly when origin mode with target t gives a nonzero flag vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| board_i | input | 256 | Occupant code of each square, 4 bits per square |
| side_i | input | 1 | Side to move (0 white, 1 black) |
| mode_i | input | 1 | 0 destination mode, 1 origin mode |
| target_i | input | 6 | Target square index used in origin mode |
| flags_o | output | 64 | Registered per-square flag vector |

## Verification
The hardest cases to reach are the ones where several kinds of signal meet at one square. Examples are a ray stopped one square short by a blocker, a pawn whose push is blocked while its capture is open, and an origin query whose target holds a friendly piece. Hand-built boards place these cases on purpose, including rays that run along the edge files and ranks where wrap-around would show. A sweep of pseudo-random boards then runs for both sides. Each board runs destination mode once and origin mode for all 64 targets, and both results are compared against a piece-by-piece loop model kept in the bench. The two mode results are also checked against each other as R10 describes.

// File: rtl/sqgrid_pkg.sv
`timescale 1ns/1ps
package sqgrid_pkg;
  localparam int NFILE  = 8;
  localparam int NRANK  = 8;
  localparam int NSQ    = NFILE * NRANK;
  localparam int SQ_W   = $clog2(NSQ);
  localparam int CODE_W = 4;
  localparam int NDIR   = 8;
  localparam int NJMP   = 8;
  localparam int TYPE_W = CODE_W - 1;

  typedef enum logic [TYPE_W-1:0] {
    PC_NONE   = 3'd0,
    PC_PAWN   = 3'd1,
    PC_KNIGHT = 3'd2,
    PC_BISHOP = 3'd3,
    PC_ROOK   = 3'd4,
    PC_QUEEN  = 3'd5,
    PC_KING   = 3'd6,
    PC_RSVD   = 3'd7
  } piece_e;

  // Direction d: 0 N, 1 NE, 2 E, 3 SE, 4 S, 5 SW, 6 W, 7 NW (even = orthogonal)
  function automatic int dir_df(input int d);
    case (d)
      1, 2, 3: return 1;
      5, 6, 7: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic int dir_dr(input int d);
    case (d)
      0, 1, 7: return 1;
      3, 4, 5: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic int jmp_df(input int k);
    case (k)
      0: return 1;   1: return 2;   2: return 2;   3: return 1;
      4: return -1;  5: return -2;  6: return -2;  default: return -1;
    endcase
  endfunction

  function automatic int jmp_dr(input int k);
    case (k)
      0: return 2;   1: return 1;   2: return -1;  3: return -2;
      4: return -2;  5: return -1;  6: return 1;   default: return 2;
    endcase
  endfunction

  // Square reached from s by a file/rank offset, or -1 when it leaves the board
  function automatic int sq_step(input int s, input int df, input int dr);
    int f;
    int r;
    f = (s % NFILE) + df;
    r = (s / NFILE) + dr;
    if (f < 0 || f >= NFILE || r < 0 || r >= NRANK) return -1;
    return r * NFILE + f;
  endfunction
endpackage

// File: rtl/sqgrid_cell.sv
`timescale 1ns/1ps
module sqgrid_cell
  import sqgrid_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              side_i,
  input  logic              mode_i,
  input  logic              tgt_i,
  input  logic [NDIR-1:0]   ray_i,
  input  logic [NDIR-1:0]   step_i,
  input  logic [NDIR-1:0]   push_i,
  input  logic [NDIR-1:0]   cap_i,
  input  logic [NJMP-1:0]   jump_i,
  output logic [NDIR-1:0]   ray_o,
  output logic [NDIR-1:0]   step_o,
  output logic [NDIR-1:0]   push_o,
  output logic [NDIR-1:0]   cap_o,
  output logic [NJMP-1:0]   jump_o,
  output logic              flag_o,
  output logic              emit_o
);
  logic [TYPE_W-1:0] kind;
  logic empty, own, enemy;
  logic is_pawn, is_knight, is_king, slide_orth, slide_diag;
  logic src_on;      // destination mode: this cell launches its piece's pattern
  logic tgt_emit;    // origin mode: this cell is the target and launches all patterns
  logic [2:0] fwd_d, back_d;
  logic [NDIR-1:0] slide_ok;
  logic vict_hit, aggr_hit;

  assign kind       = code_i[TYPE_W-1:0];
  assign empty      = (kind == PC_NONE);
  assign own        = !empty && (code_i[CODE_W-1] == side_i);
  assign enemy      = !empty && (code_i[CODE_W-1] != side_i);
  assign is_pawn    = (kind == PC_PAWN);
  assign is_knight  = (kind == PC_KNIGHT);
  assign is_king    = (kind == PC_KING);
  assign slide_orth = (kind == PC_ROOK)   || (kind == PC_QUEEN);
  assign slide_diag = (kind == PC_BISHOP) || (kind == PC_QUEEN);

  assign src_on   = !mode_i && own;
  assign tgt_emit = mode_i && tgt_i && !own;
  assign emit_o   = tgt_emit;

  // White advances north (0), black advances south (4)
  assign fwd_d  = side_i ? 3'd4 : 3'd0;
  assign back_d = side_i ? 3'd0 : 3'd4;

  always_comb begin
    for (int d = 0; d < NDIR; d++) begin
      slide_ok[d] = (d % 2 == 1) ? slide_diag : slide_orth;
      ray_o[d]    = (src_on && slide_ok[d]) || tgt_emit || (ray_i[d] && empty);
      step_o[d]   = (src_on && is_king) || tgt_emit;
      if (3'(d) == fwd_d)       push_o[d] = src_on && is_pawn;
      else if (3'(d) == back_d) push_o[d] = tgt_emit && empty;
      else                      push_o[d] = 1'b0;
      if (3'(d) == fwd_d + 3'd1 || 3'(d) == fwd_d - 3'd1)
        cap_o[d] = src_on && is_pawn;
      else if (3'(d) == back_d + 3'd1 || 3'(d) == back_d - 3'd1)
        cap_o[d] = tgt_emit && enemy;
      else
        cap_o[d] = 1'b0;
    end
    for (int k = 0; k < NJMP; k++) begin
      jump_o[k] = (src_on && is_knight) || tgt_emit;
    end
  end

  assign vict_hit = (!own && (|ray_i || |step_i || |jump_i)) ||
                    (empty && |push_i) || (enemy && |cap_i);
  assign aggr_hit = own && (|(ray_i & slide_ok) || (is_king && |step_i) ||
                    (is_knight && |jump_i) || (is_pawn && (|push_i || |cap_i)));
  assign flag_o   = mode_i ? aggr_hit : vict_hit;
endmodule

// File: rtl/sqgrid_flag_reg.sv
`timescale 1ns/1ps
module sqgrid_flag_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= d_i;
  end
endmodule

// File: rtl/sqgrid_movegen.sv
`timescale 1ns/1ps
module sqgrid_movegen
  import sqgrid_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSQ*CODE_W-1:0] board_i,
  input  logic                  side_i,
  input  logic                  mode_i,
  input  logic [SQ_W-1:0]       target_i,
  output logic [NSQ-1:0]        flags_o
);
  logic [NDIR-1:0] ray_o  [NSQ];
  logic [NDIR-1:0] step_o [NSQ];
  logic [NDIR-1:0] push_o [NSQ];
  logic [NDIR-1:0] cap_o  [NSQ];
  logic [NJMP-1:0] jump_o [NSQ];
  logic [NSQ-1:0]  flag_c;   // settled per-square flags before the register
  logic [NSQ-1:0]  emit_c;   // cells launching the origin-mode pattern

  for (genvar s = 0; s < NSQ; s++) begin : g_sq
    logic [NDIR-1:0] ray_in, step_in, push_in, cap_in;
    logic [NJMP-1:0] jump_in;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
      localparam int SRC = sq_step(s, -dir_df(d), -dir_dr(d));
      if (SRC >= 0) begin : g_link
        assign ray_in[d]  = ray_o[SRC][d];
        assign step_in[d] = step_o[SRC][d];
        assign push_in[d] = push_o[SRC][d];
        assign cap_in[d]  = cap_o[SRC][d];
      end else begin : g_edge
        assign ray_in[d]  = 1'b0;
        assign step_in[d] = 1'b0;
        assign push_in[d] = 1'b0;
        assign cap_in[d]  = 1'b0;
      end
    end

    for (genvar k = 0; k < NJMP; k++) begin : g_jmp
      localparam int JSRC = sq_step(s, -jmp_df(k), -jmp_dr(k));
      if (JSRC >= 0) begin : g_link
        assign jump_in[k] = jump_o[JSRC][k];
      end else begin : g_edge
        assign jump_in[k] = 1'b0;
      end
    end

    sqgrid_cell u_cell (
      .code_i (board_i[s*CODE_W +: CODE_W]),
      .side_i (side_i),
      .mode_i (mode_i),
      .tgt_i  (target_i == SQ_W'(s)),
      .ray_i  (ray_in),
      .step_i (step_in),
      .push_i (push_in),
      .cap_i  (cap_in),
      .jump_i (jump_in),
      .ray_o  (ray_o[s]),
      .step_o (step_o[s]),
      .push_o (push_o[s]),
      .cap_o  (cap_o[s]),
      .jump_o (jump_o[s]),
      .flag_o (flag_c[s]),
      .emit_o (emit_c[s])
    );
  end

  sqgrid_flag_reg #(.W(NSQ)) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (flag_c),
    .q_o   (flags_o)
  );
endmodule

// File: rtl/sqgrid_movegen_chk.sv
`timescale 1ns/1ps
module sqgrid_movegen_chk
  import sqgrid_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [NSQ*CODE_W-1:0] board_i,
  input logic                  side_i,
  input logic                  mode_i,
  input logic [SQ_W-1:0]       target_i,
  input logic [NSQ-1:0]        flags_o,
  input logic [NSQ-1:0]        emit_c
);
  logic [NSQ*CODE_W-1:0] board_q;
  logic                  side_q, mode_q, vld_q;
  logic [SQ_W-1:0]       tgt_q;
  logic [NSQ-1:0]        own_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      board_q <= '0;
      side_q  <= 1'b0;
      mode_q  <= 1'b0;
      tgt_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      board_q <= board_i;
      side_q  <= side_i;
      mode_q  <= mode_i;
      tgt_q   <= target_i;
      vld_q   <= 1'b1;
    end
  end

  always_comb begin
    for (int s = 0; s < NSQ; s++) begin
      own_q[s] = (board_q[s*CODE_W +: TYPE_W] != '0) &&
                 (board_q[s*CODE_W + TYPE_W] == side_q);
    end
  end

  // R5
  victim_not_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && !mode_q |-> (flags_o & own_q) == '0);

  // R8
  aggr_on_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && mode_q |-> (flags_o & ~own_q) == '0);

  // R7
  aggr_own_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && mode_q && own_q[tgt_q] |-> flags_o == '0);

  // R8
  single_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(emit_c));

  // R8
  emit_at_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit_c != '0 |-> mode_i && emit_c[target_i]);

  // R1
  empty_board_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && board_q == '0 |-> flags_o == '0);

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && board_i == board_q && side_i == side_q && mode_i == mode_q &&
    target_i == tgt_q |=> $stable(flags_o));
endmodule

bind sqgrid_movegen sqgrid_movegen_chk u_chk (.*);

// File: tb/sqgrid_movegen_tb.sv
`timescale 1ns/1ps
module sqgrid_movegen_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] board_i = '0;
  logic         side_i = 1'b0;
  logic         mode_i = 1'b0;
  logic [5:0]   target_i = '0;
  logic [63:0]  flags_o;
  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sqgrid_movegen u_dut (.clk(clk), .rst_n(rst_n), .board_i(board_i), .side_i(side_i),
                        .mode_i(mode_i), .target_i(target_i), .flags_o(flags_o));

  function automatic logic [255:0] put(input logic [255:0] b, input int s, input logic [3:0] c);
    logic [255:0] r;
    r = b;
    r[s*4 +: 4] = c;
    return r;
  endfunction

  // Loop-style reference: destination set of the piece on square s
  function automatic logic [63:0] ref_dests(input logic [255:0] b, input int s);
    logic [63:0] m;
    logic [3:0] c, o;
    int f, r, nf, nr, dr;
    int kf[8] = '{1, 2, 2, 1, -1, -2, -2, -1};
    int kr[8] = '{2, 1, -1, -2, -2, -1, 1, 2};
    m = '0;
    c = b[s*4 +: 4];
    f = s % 8;
    r = s / 8;
    case (c[2:0])
      3'd1: begin
        dr = c[3] ? -1 : 1;
        nr = r + dr;
        if (nr >= 0 && nr < 8) begin
          if (b[(nr*8+f)*4 +: 3] == 3'd0) m[nr*8+f] = 1'b1;
          for (int df = -1; df <= 1; df += 2) begin
            nf = f + df;
            if (nf >= 0 && nf < 8) begin
              o = b[(nr*8+nf)*4 +: 4];
              if (o[2:0] != 3'd0 && o[3] != c[3]) m[nr*8+nf] = 1'b1;
            end
          end
        end
      end
      3'd2: begin
        for (int k = 0; k < 8; k++) begin
          nf = f + kf[k];
          nr = r + kr[k];
          if (nf >= 0 && nf < 8 && nr >= 0 && nr < 8) begin
            o = b[(nr*8+nf)*4 +: 4];
            if (o[2:0] == 3'd0 || o[3] != c[3]) m[nr*8+nf] = 1'b1;
          end
        end
      end
      3'd3, 3'd4, 3'd5, 3'd6: begin
        for (int a = -1; a <= 1; a++) begin
          for (int e = -1; e <= 1; e++) begin
            if (a == 0 && e == 0) continue;
            if (c[2:0] == 3'd3 && (a == 0 || e == 0)) continue;
            if (c[2:0] == 3'd4 && a != 0 && e != 0) continue;
            nf = f + a;
            nr = r + e;
            while (nf >= 0 && nf < 8 && nr >= 0 && nr < 8) begin
              o = b[(nr*8+nf)*4 +: 4];
              if (o[2:0] == 3'd0) begin
                m[nr*8+nf] = 1'b1;
              end else begin
                if (o[3] != c[3]) m[nr*8+nf] = 1'b1;
                break;
              end
              if (c[2:0] == 3'd6) break;
              nf += a;
              nr += e;
            end
          end
        end
      end
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic is_own(input logic [255:0] b, input int s, input logic sd);
    return b[s*4 +: 3] != 3'd0 && b[s*4+3] == sd;
  endfunction

  function automatic logic [63:0] ref_victim(input logic [255:0] b, input logic sd);
    logic [63:0] v;
    v = '0;
    for (int s = 0; s < 64; s++) if (is_own(b, s, sd)) v |= ref_dests(b, s);
    return v;
  endfunction

  function automatic logic [63:0] ref_aggr(input logic [255:0] b, input logic sd, input int t);
    logic [63:0] a;
    logic [63:0] m;
    a = '0;
    for (int s = 0; s < 64; s++) begin
      if (is_own(b, s, sd)) begin
        m = ref_dests(b, s);
        a[s] = m[t];
      end
    end
    return a;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [255:0] b, input logic sd, input logic md,
                     input int t, output logic [63:0] res);
    @(negedge clk);
    board_i  = b;
    side_i   = sd;
    mode_i   = md;
    target_i = 6'(t);
    @(negedge clk);
    res = flags_o;
  endtask

  initial begin
    #500000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [255:0] b;
    logic [63:0] res, vict, aggr;
    void'($urandom(17));

    // R1: reset holds flags at zero even with a live board
    board_i = put('0, 0, 4'h2);
    repeat (3) @(negedge clk);
    chk("R1 reset", flags_o, 64'h0);
    rst_n = 1'b1;

    run('0, 1'b0, 1'b0, 0, res);
    chk("R1 empty board", res, 64'h0);

    // R2: rook on h1, no wrap onto a2
    b = put('0, 7, 4'h4);
    run(b, 1'b0, 1'b0, 0, res);
    chk("R2 rook edge", res, 64'h8080_8080_8080_807F);

    // R2: rook stopped by own pawn and by enemy knight
    b = put(put(put('0, 27, 4'h4), 43, 4'h1), 30, 4'hA);
    run(b, 1'b0, 1'b0, 0, res);
    chk("R2 rook blocked", res, ref_victim(b, 1'b0));

    // R3: knight in corner
    b = put('0, 0, 4'h2);
    run(b, 1'b0, 1'b0, 0, res);
    chk("R3 knight a1", res, 64'h0000_0000_0002_0400);

    // R3: king on edge square
    b = put('0, 31, 4'h6);
    run(b, 1'b0, 1'b0, 0, res);
    chk("R3 king h4", res, ref_victim(b, 1'b0));

    // R4: pawn push blocked, capture open
    b = put(put(put('0, 12, 4'h1), 20, 4'hA), 19, 4'hC);
    run(b, 1'b0, 1'b0, 0, res);
    chk("R4 pawn", res, 64'h0000_0000_0008_0000);

    // R5: queen boxed in by own pieces
    b = put(put(put(put('0, 0, 4'h5), 8, 4'h1), 9, 4'h1), 1, 4'h2);
    run(b, 1'b0, 1'b0, 0, res);
    chk("R5 own squares", res, ref_victim(b, 1'b0));
    chk("R5 no own flag", res & 64'h0000_0000_0000_0303, 64'h0);

    // R9: black pawn moves south, captures white rook
    b = put(put('0, 52, 4'h9), 43, 4'h4);
    run(b, 1'b1, 1'b0, 0, res);
    chk("R9 black pawn", res, 64'h0000_1800_0000_0000);

    // R6: several origins onto empty e4
    b = put(put(put(put(put(put('0, 4, 4'h4), 1, 4'h3), 13, 4'h2), 31, 4'h5), 35, 4'h6), 60, 4'hC);
    run(b, 1'b0, 1'b1, 28, res);
    chk("R6 origins e4", res, 64'h0000_0008_8000_2012);

    // R7: target holds own rook
    run(b, 1'b0, 1'b1, 4, res);
    chk("R7 own target", res, 64'h0);

    // R6: pawn captures onto enemy, push blocked
    b = put(put(put(put('0, 10, 4'h1), 11, 4'h1), 12, 4'h1), 19, 4'hA);
    run(b, 1'b0, 1'b1, 19, res);
    chk("R6 pawn capture origins", res, 64'h0000_0000_0000_1400);
    b = put(b, 19, 4'h0);
    run(b, 1'b0, 1'b1, 19, res);
    chk("R6 pawn push origin", res, 64'h0000_0000_0000_0800);

    // Sweep of pseudo-random boards, both sides, both modes
    for (int n = 0; n < 40; n++) begin
      b = '0;
      for (int s = 0; s < 64; s++) begin
        if ($urandom % 100 < 35)
          b = put(b, s, {1'($urandom % 2), 3'(1 + $urandom % 6)});
      end
      for (int sd = 0; sd < 2; sd++) begin
        run(b, 1'(sd), 1'b0, 0, vict);
        chk("R2/R3/R4/R5 sweep", vict, ref_victim(b, 1'(sd)));
        for (int t = 0; t < 64; t++) begin
          run(b, 1'(sd), 1'b1, t, aggr);
          chk("R6 sweep", aggr, ref_aggr(b, 1'(sd), t));
          chk("R10 consistency", {63'h0, aggr != '0}, {63'h0, vict[t]});
        end
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule